// File: doc/BRIEF.md
# Multicycle Control with Exception Entry

This block is the control state machine of a multicycle 32-bit processor, extended so that it can enter exceptions. Each instruction passes through a fetch state, a decode state and a few execution states chosen by the opcode. Two faults are detected inside the machine itself. The first is an opcode that the decoder does not recognise, which is caught in the decode state. The second is a signed overflow reported by the ALU while a register-type instruction executes.

When either fault is seen, the machine spends exactly one extra cycle in a dedicated exception state. In that cycle it makes the external ALU compute PC minus 4, because the PC already points past the faulting instruction. It stores that result as the exception return address and records a one-bit cause code. It also loads the PC with a single fixed handler address through the fourth input of the PC source multiplexer.

The register file, the memory and the ALU sit outside the block. The block supplies their strobes and select lines, and it holds the saved-address register and the cause register.

Top module: `exc_sequencer`

## Requirements
- R1: While rst_ni is low, epc_o and cause_o read zero and the machine sits in the fetch state. The fetch state is visible as ir_write_o=1, pc_write_o=1, mem_read_o=1 and pc_source_o=0.
- R2: Five opcodes decode normally and never start an exception: load 0x23 (5 cycles), store 0x2B (4 cycles), register-type 0x00 (4 cycles), branch-equal 0x04 (3 cycles) and jump 0x02 (3 cycles). Each count runs from fetch back to the next fetch.
- R3: Every other 6-bit opcode present in the decode state sends the machine, on the next cycle, into a one-cycle exception state with int_cause_o=0.
- R4: If alu_ovf_i is high in the register-type execute state (alu_op_o=2), the next cycle is the overflow exception state with int_cause_o=1. The write-back cycle is skipped, so reg_write_o stays 0 for that instruction.
- R5: In an exception cycle, alu_src_a_o=0 (PC), alu_src_b_o=1 (constant 4), alu_op_o=1 (subtract) and epc_write_o=1. epc_o then takes the value of alu_result_i.
- R6: cause_o loads the value {31 zeros, int_cause_o} only when cause_write_o is 1. The value is 0 for an undefined opcode and 1 for an overflow, and bits 31:1 are always zero.
- R7: An exception cycle asserts pc_write_o with pc_source_o=3, which drives pc_next_o to 0xC0000000. The following cycle is fetch again.
- R8: alu_ovf_i has no effect outside the register-type execute state.
- R9: pc_next_o selects by pc_source_o: 0 selects alu_result_i, 1 selects alu_out_i, 2 selects jump_addr_i and 3 selects the handler address.
- R10: epc_o and cause_o hold their values in every cycle in which their write strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Opcode field of the instruction register |
| alu_ovf_i | input | 1 | Signed overflow flag from the ALU |
| alu_result_i | input | 32 | Combinational ALU output |
| alu_out_i | input | 32 | Registered ALU output (branch target) |
| jump_addr_i | input | 32 | Assembled jump target |
| pc_write_o | output | 1 | Unconditional PC load |
| pc_write_cond_o | output | 1 | PC load qualified by the zero flag |
| iord_o | output | 1 | Memory address from ALU output instead of PC |
| mem_read_o | output | 1 | Memory read strobe |
| mem_write_o | output | 1 | Memory write strobe |
| ir_write_o | output | 1 | Instruction register load |
| mem_to_reg_o | output | 1 | Register write data from memory |
| reg_dst_o | output | 1 | Destination register from rd field |
| reg_write_o | output | 1 | Register file write |
| alu_src_a_o | output | 1 | ALU A operand: 0 is PC, 1 is register A |
| alu_src_b_o | output | 2 | ALU B operand: 0 reg B, 1 constant 4, 2 immediate, 3 immediate shifted by 2 |
| alu_op_o | output | 2 | ALU operation: 0 add, 1 subtract, 2 by function field |
| pc_source_o | output | 2 | PC source select |
| epc_write_o | output | 1 | Saved-address register load |
| cause_write_o | output | 1 | Cause register load |
| int_cause_o | output | 1 | Cause code written in this cycle |
| pc_next_o | output | 32 | Output of the PC source multiplexer |
| epc_o | output | 32 | Saved faulting-instruction address |
| cause_o | output | 32 | Cause register |

## Verification
Some properties are checked by assertions on every cycle:
- an exception cycle lasts one cycle and returns to fetch;
- it asserts all of its strobes together with the handler select;
- EPC captures the ALU output, and both saved registers hold between writes;
- Cause never carries upper bits;
- an overflow in the execute state replaces write-back.

Other behaviour needs the directed scenarios, because it depends on a datapath model in the bench:
- that the captured value really equals the faulting instruction's address;
- the fetch address after the trap;
- the cycle count of each legal opcode;
- that overflow is ignored in other states;
- that the cause code is overwritten when a second, different fault follows.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int OPC_W = 6;

  typedef enum logic [3:0] {
    ST_FETCH     = 4'd0,
    ST_DECODE    = 4'd1,
    ST_MEM_ADDR  = 4'd2,
    ST_MEM_RD    = 4'd3,
    ST_MEM_WB    = 4'd4,
    ST_MEM_WR    = 4'd5,
    ST_R_EXEC    = 4'd6,
    ST_R_WB      = 4'd7,
    ST_BRANCH    = 4'd8,
    ST_JUMP      = 4'd9,
    ST_EXC_UNDEF = 4'd10,
    ST_EXC_OVF   = 4'd11
  } state_e;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;

  localparam logic [1:0] SRCB_REG  = 2'd0;
  localparam logic [1:0] SRCB_FOUR = 2'd1;
  localparam logic [1:0] SRCB_IMM  = 2'd2;
  localparam logic [1:0] SRCB_IMM2 = 2'd3;

  localparam logic [1:0] AOP_ADD   = 2'd0;
  localparam logic [1:0] AOP_SUB   = 2'd1;
  localparam logic [1:0] AOP_FUNCT = 2'd2;

  localparam logic [1:0] PCS_ALU     = 2'd0;
  localparam logic [1:0] PCS_ALUOUT  = 2'd1;
  localparam logic [1:0] PCS_JUMP    = 2'd2;
  localparam logic [1:0] PCS_HANDLER = 2'd3;

  localparam logic CAUSE_UNDEF = 1'b0;
  localparam logic CAUSE_OVF   = 1'b1;

  typedef struct packed {
    logic       pc_write;
    logic       pc_write_cond;
    logic       iord;
    logic       mem_read;
    logic       mem_write;
    logic       ir_write;
    logic       mem_to_reg;
    logic       reg_dst;
    logic       reg_write;
    logic       alu_src_a;
    logic [1:0] alu_src_b;
    logic [1:0] alu_op;
    logic [1:0] pc_source;
    logic       epc_write;
    logic       cause_write;
    logic       int_cause;
  } ctrl_t;
endpackage

// File: rtl/exc_state_fsm.sv
module exc_state_fsm
  import exc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             alu_ovf_i,
  output state_e           state_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = ST_FETCH;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        unique case (opcode_i)
          OPC_LOAD, OPC_STORE: state_d = ST_MEM_ADDR;
          OPC_RTYPE:           state_d = ST_R_EXEC;
          OPC_BEQ:             state_d = ST_BRANCH;
          OPC_JUMP:            state_d = ST_JUMP;
          default:             state_d = ST_EXC_UNDEF;
        endcase
      end
      ST_MEM_ADDR: state_d = (opcode_i == OPC_LOAD) ? ST_MEM_RD : ST_MEM_WR;
      ST_MEM_RD:   state_d = ST_MEM_WB;
      // overflow replaces write-back, so the faulting result is never committed
      ST_R_EXEC:   state_d = alu_ovf_i ? ST_EXC_OVF : ST_R_WB;
      default:     state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/exc_ctrl_decode.sv
module exc_ctrl_decode
  import exc_pkg::*;
(
  input  state_e state_i,
  output ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (state_i)
      ST_FETCH: begin
        ctrl_o.mem_read  = 1'b1;
        ctrl_o.ir_write  = 1'b1;
        ctrl_o.alu_src_b = SRCB_FOUR;
        ctrl_o.alu_op    = AOP_ADD;
        ctrl_o.pc_write  = 1'b1;
        ctrl_o.pc_source = PCS_ALU;
      end
      ST_DECODE: begin
        ctrl_o.alu_src_b = SRCB_IMM2;
        ctrl_o.alu_op    = AOP_ADD;
      end
      ST_MEM_ADDR: begin
        ctrl_o.alu_src_a = 1'b1;
        ctrl_o.alu_src_b = SRCB_IMM;
      end
      ST_MEM_RD: begin
        ctrl_o.mem_read = 1'b1;
        ctrl_o.iord     = 1'b1;
      end
      ST_MEM_WB: begin
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
      end
      ST_MEM_WR: begin
        ctrl_o.mem_write = 1'b1;
        ctrl_o.iord      = 1'b1;
      end
      ST_R_EXEC: begin
        ctrl_o.alu_src_a = 1'b1;
        ctrl_o.alu_src_b = SRCB_REG;
        ctrl_o.alu_op    = AOP_FUNCT;
      end
      ST_R_WB: begin
        ctrl_o.reg_dst   = 1'b1;
        ctrl_o.reg_write = 1'b1;
      end
      ST_BRANCH: begin
        ctrl_o.alu_src_a     = 1'b1;
        ctrl_o.alu_src_b     = SRCB_REG;
        ctrl_o.alu_op        = AOP_SUB;
        ctrl_o.pc_write_cond = 1'b1;
        ctrl_o.pc_source     = PCS_ALUOUT;
      end
      ST_JUMP: begin
        ctrl_o.pc_write  = 1'b1;
        ctrl_o.pc_source = PCS_JUMP;
      end
      ST_EXC_UNDEF, ST_EXC_OVF: begin
        // ALU rewinds the incremented PC: PC - 4
        ctrl_o.alu_src_a   = 1'b0;
        ctrl_o.alu_src_b   = SRCB_FOUR;
        ctrl_o.alu_op      = AOP_SUB;
        ctrl_o.epc_write   = 1'b1;
        ctrl_o.cause_write = 1'b1;
        ctrl_o.int_cause   = (state_i == ST_EXC_OVF) ? CAUSE_OVF : CAUSE_UNDEF;
        ctrl_o.pc_write    = 1'b1;
        ctrl_o.pc_source   = PCS_HANDLER;
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/exc_save_regs.sv
module exc_save_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              epc_we_i,
  input  logic              cause_we_i,
  input  logic              cause_bit_i,
  input  logic [DATA_W-1:0] epc_d_i,
  output logic [DATA_W-1:0] epc_o,
  output logic [DATA_W-1:0] cause_o
);
  logic [DATA_W-1:0] epc_q;
  logic              cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_q   <= '0;
      cause_q <= 1'b0;
    end else begin
      if (epc_we_i)   epc_q   <= epc_d_i;
      if (cause_we_i) cause_q <= cause_bit_i;
    end
  end

  assign epc_o   = epc_q;
  assign cause_o = {{(DATA_W-1){1'b0}}, cause_q};
endmodule

// File: rtl/exc_pc_select.sv
module exc_pc_select #(
  parameter int              DATA_W       = 32,
  parameter logic [DATA_W-1:0] HANDLER_ADDR = 32'hC000_0000
) (
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] alu_result_i,
  input  logic [DATA_W-1:0] alu_out_i,
  input  logic [DATA_W-1:0] jump_addr_i,
  output logic [DATA_W-1:0] pc_next_o
);
  localparam int N_SRC = 4;
  logic [DATA_W-1:0] src [N_SRC];

  assign src[0] = alu_result_i;
  assign src[1] = alu_out_i;
  assign src[2] = jump_addr_i;
  assign src[3] = HANDLER_ADDR;

  assign pc_next_o = src[sel_i];
endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
  import exc_pkg::*;
#(
  parameter int                DATA_W       = 32,
  parameter logic [DATA_W-1:0] HANDLER_ADDR = 32'hC000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [5:0]        opcode_i,
  input  logic              alu_ovf_i,
  input  logic [DATA_W-1:0] alu_result_i,
  input  logic [DATA_W-1:0] alu_out_i,
  input  logic [DATA_W-1:0] jump_addr_i,
  output logic              pc_write_o,
  output logic              pc_write_cond_o,
  output logic              iord_o,
  output logic              mem_read_o,
  output logic              mem_write_o,
  output logic              ir_write_o,
  output logic              mem_to_reg_o,
  output logic              reg_dst_o,
  output logic              reg_write_o,
  output logic              alu_src_a_o,
  output logic [1:0]        alu_src_b_o,
  output logic [1:0]        alu_op_o,
  output logic [1:0]        pc_source_o,
  output logic              epc_write_o,
  output logic              cause_write_o,
  output logic              int_cause_o,
  output logic [DATA_W-1:0] pc_next_o,
  output logic [DATA_W-1:0] epc_o,
  output logic [DATA_W-1:0] cause_o
);
  state_e state;
  ctrl_t  ctrl;

  exc_state_fsm i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (opcode_i),
    .alu_ovf_i(alu_ovf_i),
    .state_o  (state)
  );

  exc_ctrl_decode i_dec (
    .state_i(state),
    .ctrl_o (ctrl)
  );

  exc_save_regs #(.DATA_W(DATA_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .epc_we_i   (ctrl.epc_write),
    .cause_we_i (ctrl.cause_write),
    .cause_bit_i(ctrl.int_cause),
    .epc_d_i    (alu_result_i),
    .epc_o      (epc_o),
    .cause_o    (cause_o)
  );

  exc_pc_select #(.DATA_W(DATA_W), .HANDLER_ADDR(HANDLER_ADDR)) i_pcsel (
    .sel_i       (ctrl.pc_source),
    .alu_result_i(alu_result_i),
    .alu_out_i   (alu_out_i),
    .jump_addr_i (jump_addr_i),
    .pc_next_o   (pc_next_o)
  );

  assign pc_write_o      = ctrl.pc_write;
  assign pc_write_cond_o = ctrl.pc_write_cond;
  assign iord_o          = ctrl.iord;
  assign mem_read_o      = ctrl.mem_read;
  assign mem_write_o     = ctrl.mem_write;
  assign ir_write_o      = ctrl.ir_write;
  assign mem_to_reg_o    = ctrl.mem_to_reg;
  assign reg_dst_o       = ctrl.reg_dst;
  assign reg_write_o     = ctrl.reg_write;
  assign alu_src_a_o     = ctrl.alu_src_a;
  assign alu_src_b_o     = ctrl.alu_src_b;
  assign alu_op_o        = ctrl.alu_op;
  assign pc_source_o     = ctrl.pc_source;
  assign epc_write_o     = ctrl.epc_write;
  assign cause_write_o   = ctrl.cause_write;
  assign int_cause_o     = ctrl.int_cause;
endmodule

// File: rtl/exc_sequencer_chk.sv
module exc_sequencer_chk #(
  parameter int                DATA_W       = 32,
  parameter logic [DATA_W-1:0] HANDLER_ADDR = 32'hC000_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              alu_ovf_i,
  input logic [DATA_W-1:0] alu_result_i,
  input logic              pc_write_o,
  input logic              ir_write_o,
  input logic              reg_write_o,
  input logic              alu_src_a_o,
  input logic [1:0]        alu_src_b_o,
  input logic [1:0]        alu_op_o,
  input logic [1:0]        pc_source_o,
  input logic              epc_write_o,
  input logic              cause_write_o,
  input logic              int_cause_o,
  input logic [DATA_W-1:0] pc_next_o,
  input logic [DATA_W-1:0] epc_o,
  input logic [DATA_W-1:0] cause_o
);
  AST_EXC_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epc_write_o |=> (!epc_write_o && ir_write_o)); // R7

  AST_EXC_TO_HANDLER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epc_write_o |-> (cause_write_o && pc_write_o && pc_next_o == HANDLER_ADDR)); // R7

  AST_EXC_REWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epc_write_o |-> (!alu_src_a_o && alu_src_b_o == 2'd1 && alu_op_o == 2'd1)); // R5

  AST_EPC_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epc_write_o |=> (epc_o == $past(alu_result_i))); // R5

  AST_EPC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !epc_write_o |=> $stable(epc_o)); // R10

  AST_CAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cause_write_o |=> $stable(cause_o)); // R10

  AST_CAUSE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_write_o |=> (cause_o == {{(DATA_W-1){1'b0}}, $past(int_cause_o)})); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_op_o == 2'd2 && alu_ovf_i) |=> (!reg_write_o && cause_write_o && int_cause_o)); // R4
endmodule

bind exc_sequencer exc_sequencer_chk #(.DATA_W(DATA_W), .HANDLER_ADDR(HANDLER_ADDR)) i_chk (.*);

// File: tb/test_exc_sequencer.sv
`timescale 1ns/1ps
module test_exc_sequencer;
  localparam logic [31:0] HANDLER = 32'hC000_0000;
  localparam logic [31:0] BR_TGT  = 32'h0000_0400;
  localparam logic [31:0] J_TGT   = 32'h0000_0800;
  localparam logic [31:0] PC_RST  = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  opcode = 6'h00;
  logic        ovf = 1'b0;
  logic [31:0] alu_result;
  logic        pc_write, pc_write_cond, iord, mem_read, mem_write, ir_write;
  logic        mem_to_reg, reg_dst, reg_write, alu_src_a;
  logic [1:0]  alu_src_b, alu_op, pc_source;
  logic        epc_write, cause_write, int_cause;
  logic [31:0] pc_next, epc, cause;
  logic [31:0] pc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // datapath model: PC register and the ALU cases used here
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc <= PC_RST;
    else if (pc_write) pc <= pc_next;
  end

  always_comb begin
    if (!alu_src_a && alu_src_b == 2'd1 && alu_op == 2'd0)      alu_result = pc + 32'd4;
    else if (!alu_src_a && alu_src_b == 2'd1 && alu_op == 2'd1) alu_result = pc - 32'd4;
    else                                                        alu_result = 32'h0000_1234;
  end

  exc_sequencer i_exc_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(opcode), .alu_ovf_i(ovf),
    .alu_result_i(alu_result), .alu_out_i(BR_TGT), .jump_addr_i(J_TGT),
    .pc_write_o(pc_write), .pc_write_cond_o(pc_write_cond), .iord_o(iord),
    .mem_read_o(mem_read), .mem_write_o(mem_write), .ir_write_o(ir_write),
    .mem_to_reg_o(mem_to_reg), .reg_dst_o(reg_dst), .reg_write_o(reg_write),
    .alu_src_a_o(alu_src_a), .alu_src_b_o(alu_src_b), .alu_op_o(alu_op),
    .pc_source_o(pc_source), .epc_write_o(epc_write), .cause_write_o(cause_write),
    .int_cause_o(int_cause), .pc_next_o(pc_next), .epc_o(epc), .cause_o(cause)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 epc", epc, 32'h0);
    chk("R1 cause", cause, 32'h0);
    chk("R1 fetch", {31'b0, ir_write & pc_write & mem_read}, 32'h1);
    chk("R1 pcsrc", {30'b0, pc_source}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R3: illegal opcode traps from decode
  task automatic t_undef(input logic [5:0] op);
    logic [31:0] start;
    opcode = op;
    start = pc;
    chk("R3 at fetch", {31'b0, ir_write}, 32'h1);
    step();
    chk("R3 decode no trap yet", {31'b0, epc_write}, 32'h0);
    step();
    chk("R3 trap cycle", {31'b0, cause_write & epc_write}, 32'h1);
    chk("R6 int_cause undef", {31'b0, int_cause}, 32'h0);
    chk("R5 alu rewinds", alu_result, start);
    chk("R7 handler sel", pc_next, HANDLER);
    step();
    chk("R5 epc", epc, start);
    chk("R6 cause", cause, 32'h0);
    chk("R7 pc", pc, HANDLER);
    chk("R7 back to fetch", {31'b0, ir_write}, 32'h1);
  endtask

  task automatic t_rtype(input logic with_ovf);
    logic [31:0] start, epc0, cause0;
    opcode = 6'h00;
    ovf = with_ovf;
    start = pc; epc0 = epc; cause0 = cause;
    step();
    step();
    chk("R4 execute", {30'b0, alu_op}, 32'd2);
    step();
    if (with_ovf) begin
      chk("R4 no write-back", {31'b0, reg_write}, 32'h0);
      chk("R4 ovf trap", {31'b0, cause_write & int_cause}, 32'h1);
      chk("R5 alu rewinds", alu_result, start);
      step();
      chk("R5 epc ovf", epc, start);
      chk("R6 cause ovf", cause, 32'h1);
      chk("R7 pc ovf", pc, HANDLER);
      chk("R7 fetch after ovf", {31'b0, ir_write}, 32'h1);
    end else begin
      chk("R2 rtype write-back", {31'b0, reg_write & ~epc_write}, 32'h1);
      step();
      chk("R10 epc held", epc, epc0);
      chk("R10 cause held", cause, cause0);
      chk("R2 rtype pc", pc, start + 32'd4);
    end
    ovf = 1'b0;
  endtask

  // R2 / R8 / R9: legal opcodes, overflow held high throughout
  task automatic t_legal(input logic [5:0] op, input int exp_cyc,
                         input logic [31:0] exp_pc, input string tag);
    logic [31:0] epc0, cause0, start;
    int n = 0;
    bit trap = 1'b0;
    opcode = op;
    ovf = 1'b1;
    start = pc; epc0 = epc; cause0 = cause;
    do begin
      if (epc_write || cause_write) trap = 1'b1;
      if (pc_write_cond) chk("R9 branch target", pc_next, BR_TGT);
      if (pc_source == 2'd2) chk("R9 jump target", pc_next, J_TGT);
      step();
      n++;
    end while (!ir_write && n < 10);
    chk({"R2 cycles ", tag}, n, exp_cyc);
    chk({"R8 no trap ", tag}, {31'b0, trap}, 32'h0);
    chk({"R10 epc ", tag}, epc, epc0);
    chk({"R10 cause ", tag}, cause, cause0);
    chk({"R9 pc ", tag}, pc, (exp_pc == 32'h0) ? start + 32'd4 : exp_pc);
    ovf = 1'b0;
  endtask

  initial begin
    t_reset();
    t_legal(6'h23, 5, 32'h0, "load");
    t_legal(6'h2B, 4, 32'h0, "store");
    t_rtype(1'b0);
    t_undef(6'h3F);
    t_legal(6'h04, 3, 32'h0, "beq");
    t_legal(6'h02, 3, J_TGT, "jump");
    t_rtype(1'b1);
    t_undef(6'h01);
    t_rtype(1'b1);
    t_undef(6'h08);
    t_undef(6'h22);
    t_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule